// File: doc/BRIEF.md
# Configuration soft-reset detector with latency bytes

This block is a small slice of a PCI adapter's configuration space. Some hosts reboot without pulsing the PCI reset line. They only clear the command register's bus-master, memory-space and I/O-space enables before running diagnostics. The block watches those three enables. When all of them fall to zero together, it emits a one-cycle adapter-reset pulse, which acts like software setting the adapter's reset control bit. A single disable bit at configuration offset 40h suppresses this detection. In that case a rebooted host has to reconfigure the adapter without resetting it.

The block also holds two read-only latency bytes: a minimum grant byte at offset 3Eh and a maximum latency byte at offset 3Fh. Each counts quarter-microsecond units. They are loaded from an EEPROM image when the reset-end strobe arrives. If the image's checksum was flagged bad, both bytes take the default 0x00.

Detection is a three-state machine:
- QUIET: the last sampled enables were all zero. This is the reset state.
- LIVE: at least one enable was set.
- PULSE: a soft reset is being issued.

The transitions are:
- QUIET→LIVE when any enable is set.
- LIVE→PULSE when all enables are clear and the disable bit is 0.
- LIVE→QUIET when all enables are clear and the disable bit is 1.
- PULSE→QUIET when the enables are still all clear.
- PULSE→LIVE when any enable is set again.

All other cases hold the current state.

Top module: `cfg_rstlat`

## Requirements
- R1: At offset 40h, bit 0 is the soft-reset disable bit, written from cfg_wdata[0]. Reads of 40h return 0 in bits 7:1, and writes to those bits have no effect.
- R2: Hard reset (rst_n low) clears the disable bit, both latency bytes and the adapter-reset output.
- R3: If at one clock edge all three enables are sampled 0, the previous sample had at least one set, and the disable bit is 0, then adapter_rst is 1 for exactly the next cycle.
- R4: No pulse occurs while any enable is still 1. This includes clearing the bus-master enable alone, or clearing any two of the three.
- R5: Staying in the all-zero state never produces a second pulse. Leaving hard reset with all enables already 0 produces no pulse.
- R6: With the disable bit at 1, clearing all enables produces no pulse. Clearing the disable bit later, while the enables are still 0, does not produce a late pulse.
- R7: An ee_load cycle with ee_csum_ok=1 loads ee_min_gnt into offset 3Eh and ee_max_lat into offset 3Fh. The new values are readable from the next cycle.
- R8: An ee_load cycle with ee_csum_ok=0 sets both latency bytes to 0x00.
- R9: Offsets 3Eh and 3Fh are read-only. Configuration writes to them are ignored, and the bytes change only on ee_load.
- R10: Reads of any offset other than 3Eh, 3Fh and 40h return 0x00.
- R11: cfg_rdata follows cfg_addr combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Hard PCI reset, active low, asynchronous |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte for cfg_addr |
| cmd_bm_en | input | 1 | Command register bus-master enable |
| cmd_mem_en | input | 1 | Command register memory-space enable |
| cmd_io_en | input | 1 | Command register I/O-space enable |
| ee_load | input | 1 | Reset-end strobe, one cycle |
| ee_min_gnt | input | 8 | EEPROM minimum grant byte |
| ee_max_lat | input | 8 | EEPROM maximum latency byte |
| ee_csum_ok | input | 1 | EEPROM checksum valid |
| adapter_rst | output | 1 | One-cycle adapter software reset pulse |

## Verification
The assertions check several properties on every cycle:
- Every fall of the enables to all-zero with detection enabled yields a pulse on the next cycle.
- A pulse never lasts two cycles, and never follows an enable sample that was nonzero or a disable bit that was set.
- The latency bytes change only on ee_load, and then take the image or zero according to the checksum.
- The reserved bits of 40h and all unmapped offsets read as zero.

Some behaviour only the directed scenarios can show:
- The absence of pulses over long stretches in the all-zero state.
- The partial-clear patterns.
- Releasing the disable bit while the enables are still cleared.
- The reset values seen through reads.

// File: rtl/cfg_rstlat_pkg.sv
package cfg_rstlat_pkg;

    localparam int unsigned CFG_AW = 8;
    localparam int unsigned CFG_DW = 8;
    localparam int unsigned N_ENABLES = 3;
    localparam int unsigned N_LAT = 2;

    localparam logic [CFG_AW-1:0] OFS_MIN_GNT = 8'h3E;
    localparam logic [CFG_AW-1:0] OFS_MAX_LAT = 8'h3F;
    localparam logic [CFG_AW-1:0] OFS_SRST    = 8'h40;

    localparam logic [CFG_DW-1:0] LAT_DEFAULT = '0;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_LIVE  = 2'd1,
        ST_PULSE = 2'd2
    } srst_state_t;

endpackage

// File: rtl/srst_fsm.sv
module srst_fsm
    import cfg_rstlat_pkg::*;
#(
    parameter int unsigned NE = N_ENABLES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] en_vec,
    input  logic          det_dis,
    output logic          rst_pulse
);

    srst_state_t state_q;
    srst_state_t state_d;
    logic        any_en;

    assign any_en = |en_vec;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (any_en) state_d = ST_LIVE;
            end
            ST_LIVE: begin
                if (!any_en) state_d = det_dis ? ST_QUIET : ST_PULSE;
            end
            ST_PULSE: begin
                state_d = any_en ? ST_LIVE : ST_QUIET;
            end
            default: state_d = ST_QUIET;
        endcase
    end

    // outputs (Moore)
    always_comb begin
        rst_pulse = 1'b0;
        unique case (state_q)
            ST_PULSE: rst_pulse = 1'b1;
            default:  rst_pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/lat_regs.sv
module lat_regs
    import cfg_rstlat_pkg::*;
#(
    parameter int unsigned W   = CFG_DW,
    parameter int unsigned N   = N_LAT,
    parameter logic [W-1:0] DEF = LAT_DEFAULT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                csum_ok,
    input  logic [N-1:0][W-1:0] img,
    output logic [N-1:0][W-1:0] val
);

    for (genvar g = 0; g < N; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val[g] <= DEF;
            end else if (load) begin
                val[g] <= csum_ok ? img[g] : DEF;
            end
        end
    end

endmodule

// File: rtl/cfg_port.sv
module cfg_port
    import cfg_rstlat_pkg::*;
#(
    parameter int unsigned AW = CFG_AW,
    parameter int unsigned DW = CFG_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] min_gnt,
    input  logic [DW-1:0] max_lat,
    output logic [DW-1:0] rdata,
    output logic          det_dis
);

    localparam int unsigned PAD_W = DW - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_dis <= 1'b0;
        end else if (wr && (addr == OFS_SRST)) begin
            det_dis <= wdata[0];
        end
    end

    always_comb begin
        unique case (addr)
            OFS_MIN_GNT: rdata = min_gnt;
            OFS_MAX_LAT: rdata = max_lat;
            OFS_SRST:    rdata = {{PAD_W{1'b0}}, det_dis};
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfg_rstlat.sv
module cfg_rstlat
    import cfg_rstlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    input  logic              cmd_bm_en,
    input  logic              cmd_mem_en,
    input  logic              cmd_io_en,
    input  logic              ee_load,
    input  logic [CFG_DW-1:0] ee_min_gnt,
    input  logic [CFG_DW-1:0] ee_max_lat,
    input  logic              ee_csum_ok,
    output logic              adapter_rst
);

    logic [N_LAT-1:0][CFG_DW-1:0] lat_img;
    logic [N_LAT-1:0][CFG_DW-1:0] lat_val;
    logic [CFG_DW-1:0]            min_gnt_q;
    logic [CFG_DW-1:0]            max_lat_q;
    logic                         srst_dis;

    assign lat_img[0] = ee_min_gnt;
    assign lat_img[1] = ee_max_lat;
    assign min_gnt_q  = lat_val[0];
    assign max_lat_q  = lat_val[1];

    lat_regs #(.W(CFG_DW), .N(N_LAT), .DEF(LAT_DEFAULT)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ee_load),
        .csum_ok (ee_csum_ok),
        .img     (lat_img),
        .val     (lat_val)
    );

    cfg_port #(.AW(CFG_AW), .DW(CFG_DW)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (cfg_addr),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .min_gnt (min_gnt_q),
        .max_lat (max_lat_q),
        .rdata   (cfg_rdata),
        .det_dis (srst_dis)
    );

    srst_fsm #(.NE(N_ENABLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_vec    ({cmd_bm_en, cmd_mem_en, cmd_io_en}),
        .det_dis   (srst_dis),
        .rst_pulse (adapter_rst)
    );

endmodule

// File: rtl/cfg_rstlat_chk.sv
module cfg_rstlat_chk
    import cfg_rstlat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [CFG_DW-1:0] cfg_rdata,
    input logic              all_zero,
    input logic              srst_dis,
    input logic              adapter_rst,
    input logic              ee_load,
    input logic              ee_csum_ok,
    input logic [CFG_DW-1:0] ee_min_gnt,
    input logic [CFG_DW-1:0] ee_max_lat,
    input logic [CFG_DW-1:0] min_gnt_q,
    input logic [CFG_DW-1:0] max_lat_q
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_fire_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (all_zero && !$past(all_zero) && !srst_dis) |=> adapter_rst);

    assert_single_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        adapter_rst |=> !adapter_rst);

    assert_needs_clear_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        adapter_rst |-> $past(all_zero));

    assert_dis_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        adapter_rst |-> !$past(srst_dis));

    assert_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == OFS_SRST) |-> (cfg_rdata[CFG_DW-1:1] == '0));

    assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr != OFS_SRST && cfg_addr != OFS_MIN_GNT && cfg_addr != OFS_MAX_LAT)
        |-> (cfg_rdata == '0));

    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_load && ee_csum_ok) |=>
        (min_gnt_q == $past(ee_min_gnt) && max_lat_q == $past(ee_max_lat)));

    assert_badsum_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_load && !ee_csum_ok) |=> (min_gnt_q == '0 && max_lat_q == '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !ee_load |=> ($stable(min_gnt_q) && $stable(max_lat_q)));

endmodule

bind cfg_rstlat cfg_rstlat_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_addr    (cfg_addr),
    .cfg_rdata   (cfg_rdata),
    .all_zero    (!(cmd_bm_en || cmd_mem_en || cmd_io_en)),
    .srst_dis    (srst_dis),
    .adapter_rst (adapter_rst),
    .ee_load     (ee_load),
    .ee_csum_ok  (ee_csum_ok),
    .ee_min_gnt  (ee_min_gnt),
    .ee_max_lat  (ee_max_lat),
    .min_gnt_q   (min_gnt_q),
    .max_lat_q   (max_lat_q)
);

// File: tb/cfg_rstlat_tb_top.sv
`timescale 1ns/1ps
module cfg_rstlat_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       cmd_bm_en = 1'b0;
    logic       cmd_mem_en = 1'b0;
    logic       cmd_io_en = 1'b0;
    logic       ee_load = 1'b0;
    logic [7:0] ee_min_gnt = '0;
    logic [7:0] ee_max_lat = '0;
    logic       ee_csum_ok = 1'b0;
    logic       adapter_rst;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cfg_rstlat dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cmd_bm_en(cmd_bm_en), .cmd_mem_en(cmd_mem_en), .cmd_io_en(cmd_io_en),
        .ee_load(ee_load), .ee_min_gnt(ee_min_gnt), .ee_max_lat(ee_max_lat),
        .ee_csum_ok(ee_csum_ok), .adapter_rst(adapter_rst)
    );

    always @(negedge clk) if (adapter_rst) pulses++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, int'(cfg_rdata), int'(exp));
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic ee_present(input logic [7:0] mg, input logic [7:0] ml, input logic ok);
        @(negedge clk);
        ee_min_gnt = mg; ee_max_lat = ml; ee_csum_ok = ok; ee_load = 1'b1;
        @(negedge clk);
        ee_load = 1'b0; ee_min_gnt = 8'hA5; ee_max_lat = 8'h5A;
    endtask

    task automatic set_en(input logic bm, input logic mem, input logic io);
        @(negedge clk);
        cmd_bm_en = bm; cmd_mem_en = mem; cmd_io_en = io;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R2 adapter_rst after reset", int'(adapter_rst), 0);
        rd_check("R2 min_gnt reset", 8'h3E, 8'h00);
        rd_check("R2 max_lat reset", 8'h3F, 8'h00);
        rd_check("R2 disable bit reset", 8'h40, 8'h00);
        wait_cyc(4);
        check("R5 no pulse leaving reset with enables zero", pulses, 0);
    endtask

    task automatic t_eeprom;
        ee_present(8'h12, 8'h34, 1'b1);
        rd_check("R7 min_gnt loaded", 8'h3E, 8'h12);
        rd_check("R7 max_lat loaded", 8'h3F, 8'h34);
        ee_present(8'h55, 8'h66, 1'b0);
        rd_check("R8 min_gnt default on bad checksum", 8'h3E, 8'h00);
        rd_check("R8 max_lat default on bad checksum", 8'h3F, 8'h00);
        ee_present(8'h9C, 8'h07, 1'b1);
        cfg_write(8'h3E, 8'hFF);
        cfg_write(8'h3F, 8'hFF);
        rd_check("R9 min_gnt write ignored", 8'h3E, 8'h9C);
        rd_check("R9 max_lat write ignored", 8'h3F, 8'h07);
    endtask

    task automatic t_ctrl_reg;
        cfg_write(8'h40, 8'hFF);
        rd_check("R1 disable set, reserved read zero", 8'h40, 8'h01);
        cfg_write(8'h40, 8'hFE);
        rd_check("R1 disable cleared by bit0=0", 8'h40, 8'h00);
        // same-cycle read: R11
        @(negedge clk);
        cfg_addr = 8'h3E; #0.5;
        check("R11 combinational read 3Eh", int'(cfg_rdata), 8'h9C);
        cfg_addr = 8'h3F; #0.5;
        check("R11 combinational read 3Fh", int'(cfg_rdata), 8'h07);
    endtask

    task automatic t_unmapped;
        rd_check("R10 offset 00h", 8'h00, 8'h00);
        rd_check("R10 offset 3Dh", 8'h3D, 8'h00);
        rd_check("R10 offset 41h", 8'h41, 8'h00);
        rd_check("R10 offset FFh", 8'hFF, 8'h00);
    endtask

    task automatic t_partial;
        int base;
        set_en(1, 1, 1); wait_cyc(3);
        base = pulses;
        set_en(0, 1, 1); wait_cyc(4);
        check("R4 bus-master cleared alone", pulses - base, 0);
        set_en(0, 0, 1); wait_cyc(4);
        check("R4 two enables cleared", pulses - base, 0);
        set_en(1, 0, 0); wait_cyc(4);
        check("R4 only bus-master left", pulses - base, 0);
    endtask

    task automatic t_soft_reset;
        int base;
        set_en(1, 1, 1); wait_cyc(3);
        base = pulses;
        set_en(0, 0, 0);
        @(negedge clk);
        check("R3 pulse in cycle after all-zero sample", int'(adapter_rst), 1);
        @(negedge clk);
        check("R3 pulse lasts one cycle", int'(adapter_rst), 0);
        wait_cyc(20);
        check("R5 no retrigger while all zero", pulses - base, 1);
        set_en(0, 1, 0); wait_cyc(2);
        base = pulses;
        set_en(0, 0, 0); wait_cyc(5);
        check("R3 memory enable falling last", pulses - base, 1);
    endtask

    task automatic t_disabled;
        int base;
        set_en(1, 1, 1);
        cfg_write(8'h40, 8'h01);
        base = pulses;
        set_en(0, 0, 0); wait_cyc(6);
        check("R6 disable suppresses pulse", pulses - base, 0);
        cfg_write(8'h40, 8'h00);
        wait_cyc(6);
        check("R6 no late pulse after re-enable", pulses - base, 0);
        rd_check("R1 disable readback cleared", 8'h40, 8'h00);
        set_en(0, 0, 1); wait_cyc(2);
        set_en(0, 0, 0); wait_cyc(4);
        check("R3 detection works again", pulses - base, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_eeprom();
        t_ctrl_reg();
        t_unmapped();
        t_partial();
        t_soft_reset();
        t_disabled();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule